// File: doc/BRIEF.md
# Edge-Triggered Interrupt Priority Controller

This block watches four active-low trigger pins, numbered 1, 2, 5 and 6, that idle high through external pull-ups. Every pin is synchronised and debounced, and both its falling and its rising transition can raise a request. Each of the eight edge requests has its own enable bit. The bits are held in two 8-bit enable registers, which a simple write port loads.

Pending requests are resolved every cycle by a fixed priority chain. A power-on initialisation request sits at the top of the chain and a software jump request sits at the bottom. The winner appears as a vector number together with a valid flag. The downstream sequencer acknowledges the presented vector, and that acknowledgement retires it. Any other pending requests then take their turn in priority order.

Top module: `trig_vector_ctrl`

## Requirements
- R1: After reset, `vec_valid` is 0 until the power-on delay expires. Every used enable bit resets to 1, so all eight edges are enabled.
- R2: A write with `en_sel`=0 loads the enables for pins 1 and 2, and a write with `en_sel`=1 loads those for pins 5 and 6. In each register, bit 0 enables the falling edge of the lower pin and bit 1 the falling edge of the higher pin. Bit 4 enables the rising edge of the lower pin and bit 5 the rising edge of the higher pin.
- R3: An edge is recognised only after the pin has held its new level for the full debounce count. That count is `LONG_CYC` clocks when `deb_long`=1 and `SHORT_CYC` clocks when `deb_long`=0. A shorter pulse produces no request, and the count restarts.
- R4: The vectors are fixed. Falling edges map as pin1 0, pin2 1, pin5 8 and pin6 9. Rising edges map as pin1 4, pin2 5, pin5 12 and pin6 13. Power-on initialisation uses vector 32.
- R5: When several requests are pending, only the highest-priority one is presented. The order, from highest, is: power-on, pin1 fall, pin1 rise, pin2 fall, pin2 rise, pin5 fall, pin5 rise, pin6 fall, pin6 rise, jump.
- R6: A single power-on request becomes pending `POR_CYC` clocks after reset release and is presented with vector 32.
- R7: A request stays presented until `vec_ack` is high in a cycle that presents it. The acknowledgement retires only that request.
- R8: Writing 0 to an enable bit also drops any pending request for that edge.
- R9: A pulse on `jump_req` queues a jump request, whose vector is the `jump_vec` value captured with it. The jump request has the lowest priority of all.
- R10: Enable bits 2, 3, 6 and 7 are ignored. Writing 0xCC disables every edge of the addressed pin pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_n | input | 4 | Raw trigger pins; index 0..3 = pins 1, 2, 5, 6 |
| deb_long | input | 1 | 1 selects the long debounce count, 0 the short |
| en_we | input | 1 | Enable register write strobe |
| en_sel | input | 1 | 0 = pins 1/2 register, 1 = pins 5/6 register |
| en_wdata | input | 8 | Enable register write data |
| jump_req | input | 1 | One-cycle jump request |
| jump_vec | input | 8 | Target vector captured with `jump_req` |
| vec_ack | input | 1 | Acknowledges the presented vector |
| vec_valid | output | 1 | A request is presented |
| vec_num | output | 8 | Vector number of the presented request |

## Verification
The hardest situation to reach is several requests pending in the same cycle. In that case the order of presentation, not merely the first vector, must be correct. The bench drives two pins low on the same clock, so both debouncers finish in the same cycle. It then adds a jump pulse while an edge request is still unacknowledged, and checks each vector in turn as it is acknowledged. It also clears an enable bit while that edge's request is still presented.

// File: rtl/trig_pkg.sv
// Shared definitions for the trigger vector controller.
// Request index order is the priority order: lower index wins.
package trig_pkg;
    localparam int NUM_PINS  = 4;
    localparam int NUM_EDGES = 2 * NUM_PINS;
    localparam int NUM_SRC   = NUM_EDGES + 2;   // power-on + edges + jump
    localparam int SRC_POI   = 0;
    localparam int SRC_JUMP  = NUM_SRC - 1;

    // Fixed vector for a source index (jump vector supplied at run time).
    function automatic logic [7:0] src_vector(input int idx);
        int pin;
        int rise;
        if (idx == SRC_POI) return 8'd32;
        pin  = (idx - 1) / 2;
        rise = (idx - 1) % 2;
        // pins 1,2 -> 0,1 ; pins 5,6 -> 8,9 ; rising edges add 4
        return 8'((pin % 2) + 8 * (pin / 2) + 4 * rise);
    endfunction
endpackage

// File: rtl/trig_debounce.sv
// One-pin synchroniser and debouncer.
// Assumes the pin idles high. Emits a one-cycle pulse when the synchronised
// level has differed from the accepted level for limit_m1+1 clocks in a row.
module trig_debounce #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_n,
    input  logic [CW-1:0] limit_m1,
    output logic          fall_p,
    output logic          rise_p
);
    logic          s1, s2, level;
    logic [CW-1:0] cnt;

    // two-stage synchroniser, resets to the idle-high level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= pin_n;
            s2 <= s1;
        end
    end

    // hold counter: accepts a new level only after a full uninterrupted run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level  <= 1'b1;
            cnt    <= '0;
            fall_p <= 1'b0;
            rise_p <= 1'b0;
        end else begin
            fall_p <= 1'b0;
            rise_p <= 1'b0;
            if (s2 == level) begin
                cnt <= '0;
            end else if (cnt == limit_m1) begin
                level  <= s2;
                cnt    <= '0;
                fall_p <= ~s2;
                rise_p <= s2;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R3: accepted level moves only at the end of a full hold run
    a_r3_level_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level) |-> (fall_p || rise_p));
    a_r3_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall_p && rise_p));
endmodule

// File: rtl/trig_prio.sv
// Fixed-priority selector over all request sources.
// Assumes req index order is priority order (index 0 highest).
module trig_prio
    import trig_pkg::*;
(
    input  logic [NUM_SRC-1:0] req,
    input  logic [7:0]         jump_vec,
    output logic [NUM_SRC-1:0] grant,
    output logic               valid,
    output logic [7:0]         vec
);
    // scan from lowest priority upward so the highest request is kept
    always_comb begin
        grant = '0;
        vec   = 8'd0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant = '0;
                grant[i] = 1'b1;
                vec = (i == SRC_JUMP) ? jump_vec : src_vector(i);
            end
        end
        valid = |req;
    end

    // R5: never more than one winner
    a_r5_one_grant: assert final ($onehot0(grant));
endmodule

// File: rtl/trig_vector_ctrl.sv
// Trigger pins to interrupt vector: debounce, per-edge enable, pending
// capture and fixed-priority presentation with acknowledge.
// Assumes vec_ack is asserted only while vec_valid is high.
module trig_vector_ctrl
    import trig_pkg::*;
#(
    parameter int LONG_CYC  = 150000,
    parameter int SHORT_CYC = 1200,
    parameter int POR_CYC   = 480000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] trig_n,
    input  logic       deb_long,
    input  logic       en_we,
    input  logic       en_sel,
    input  logic [7:0] en_wdata,
    input  logic       jump_req,
    input  logic [7:0] jump_vec,
    input  logic       vec_ack,
    output logic       vec_valid,
    output logic [7:0] vec_num
);
    localparam int DCW = $clog2(LONG_CYC + 1);
    localparam int PCW = $clog2(POR_CYC + 1);

    logic [NUM_PINS-1:0]  fall_p, rise_p;
    logic [NUM_EDGES-1:0] en_bits, en_next, edge_set, edge_pend;
    logic [NUM_SRC-1:0]   req, grant;
    logic                 poi_pend, poi_done, jump_pend;
    logic [PCW-1:0]       por_cnt;
    logic [7:0]           jump_hold;
    logic [DCW-1:0]       limit_m1;

    assign limit_m1 = deb_long ? DCW'(LONG_CYC - 1) : DCW'(SHORT_CYC - 1);

    // one debouncer per pin
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        trig_debounce #(.CW(DCW)) u_deb (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_n    (trig_n[p]),
            .limit_m1 (limit_m1),
            .fall_p   (fall_p[p]),
            .rise_p   (rise_p[p])
        );
        assign edge_set[2*p]   = fall_p[p];
        assign edge_set[2*p+1] = rise_p[p];
    end

    // next enable image: en_bits[2p+r] = pin p, r=1 rising
    always_comb begin
        en_next = en_bits;
        if (en_we) begin
            en_next[4*en_sel + 0] = en_wdata[0];
            en_next[4*en_sel + 1] = en_wdata[4];
            en_next[4*en_sel + 2] = en_wdata[1];
            en_next[4*en_sel + 3] = en_wdata[5];
        end
    end

    // enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) en_bits <= '1;
        else        en_bits <= en_next;
    end

    // edge pending: set on enabled edge, cleared by ack or disable
    always_ff @(posedge clk) begin
        if (!rst_n) edge_pend <= '0;
        else edge_pend <= ((edge_pend & ~(grant[NUM_EDGES:1] & {NUM_EDGES{vec_ack}}))
                           | edge_set) & en_next;
    end

    // power-on timer: raises one request after POR_CYC clocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            por_cnt  <= '0;
            poi_done <= 1'b0;
            poi_pend <= 1'b0;
        end else begin
            if (!poi_done) begin
                if (por_cnt == PCW'(POR_CYC - 1)) begin
                    poi_done <= 1'b1;
                    poi_pend <= 1'b1;
                end else begin
                    por_cnt <= por_cnt + 1'b1;
                end
            end
            if (vec_ack && grant[SRC_POI]) poi_pend <= 1'b0;
        end
    end

    // jump request capture with its target vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            jump_pend <= 1'b0;
            jump_hold <= 8'd0;
        end else if (jump_req) begin
            jump_pend <= 1'b1;
            jump_hold <= jump_vec;
        end else if (vec_ack && grant[SRC_JUMP]) begin
            jump_pend <= 1'b0;
        end
    end

    assign req = {jump_pend, edge_pend, poi_pend};

    trig_prio u_prio (
        .req      (req),
        .jump_vec (jump_hold),
        .grant    (grant),
        .valid    (vec_valid),
        .vec      (vec_num)
    );

    // R6: the power-on request outranks everything
    a_r6_poi_first: assert property (@(posedge clk) disable iff (!rst_n)
        poi_pend |-> (vec_num == 8'd32));
    // R7: an unacknowledged vector does not vanish
    a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !vec_ack && !en_we) |=> vec_valid);
    // R9: jump is presented only when nothing else is pending
    a_r9_jump_last: assert property (@(posedge clk) disable iff (!rst_n)
        grant[SRC_JUMP] |-> (!poi_pend && edge_pend == '0));
    // R8: a disabled edge holds no pending request
    for (genvar k = 0; k < NUM_EDGES; k++) begin : g_chk
        a_r8_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !en_bits[k] |-> !edge_pend[k]);
    end
endmodule

// File: tb/tb_trig_vector_ctrl.sv
module tb_trig_vector_ctrl;
    localparam int LONG  = 12;
    localparam int SHORT = 4;
    localparam int POR   = 20;
    localparam logic [7:0] NONE = 8'hFF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] trig_n = 4'hF;
    logic       deb_long = 1'b0;
    logic       en_we = 1'b0;
    logic       en_sel = 1'b0;
    logic [7:0] en_wdata = 8'h00;
    logic       jump_req = 1'b0;
    logic [7:0] jump_vec = 8'h00;
    logic       vec_ack = 1'b0;
    logic       vec_valid;
    logic [7:0] vec_num;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    trig_vector_ctrl #(.LONG_CYC(LONG), .SHORT_CYC(SHORT), .POR_CYC(POR)) dut (
        .clk(clk), .rst_n(rst_n), .trig_n(trig_n), .deb_long(deb_long),
        .en_we(en_we), .en_sel(en_sel), .en_wdata(en_wdata),
        .jump_req(jump_req), .jump_vec(jump_vec), .vec_ack(vec_ack),
        .vec_valid(vec_valid), .vec_num(vec_num)
    );

    // row: en0, en1, pin index, expected fall vector, expected rise vector
    typedef struct packed {
        logic [7:0] e0;
        logic [7:0] e1;
        logic [1:0] pin;
        logic [7:0] vf;
        logic [7:0] vr;
    } row_t;
    localparam row_t ROWS [8] = '{
        '{8'h33, 8'h33, 2'd0, 8'd0,  8'd4},   // R4 pin1
        '{8'h33, 8'h33, 2'd1, 8'd1,  8'd5},   // R4 pin2
        '{8'h33, 8'h33, 2'd2, 8'd8,  8'd12},  // R4 pin5
        '{8'h33, 8'h33, 2'd3, 8'd9,  8'd13},  // R4 pin6
        '{8'h01, 8'h00, 2'd0, 8'd0,  NONE},   // R2 pin1 fall only
        '{8'h10, 8'h00, 2'd0, NONE,  8'd4},   // R2 pin1 rise only
        '{8'h00, 8'h20, 2'd3, NONE,  8'd13},  // R2 pin6 rise only
        '{8'h00, 8'h02, 2'd3, 8'd9,  NONE}    // R2 pin6 fall only
    };

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_vec(input string req, input logic [7:0] exp);
        total++;
        if (exp == NONE) begin
            if (vec_valid !== 1'b0) begin
                bad++;
                $display("FAIL %s: valid=%0b vec=%0d expected no vector", req, vec_valid, vec_num);
            end
        end else if (vec_valid !== 1'b1 || vec_num !== exp) begin
            bad++;
            $display("FAIL %s: valid=%0b vec=%0d expected valid vec=%0d", req, vec_valid, vec_num, exp);
        end
    endtask

    task automatic ack();
        vec_ack = 1'b1;
        tick(1);
        vec_ack = 1'b0;
    endtask

    task automatic wr_en(input logic sel, input logic [7:0] d);
        en_sel = sel; en_wdata = d; en_we = 1'b1;
        tick(1);
        en_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++;
            $display("FAIL watchdog: cycles=%0d expected < 20000", cyc);
            finish_run();
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        expect_vec("R1 reset idle", NONE);
        tick(POR);
        expect_vec("R6 power-on vector", 8'd32);
        tick(3);
        expect_vec("R7 held without ack", 8'd32);
        ack();
        expect_vec("R6 single power-on", NONE);

        // table walk, short debounce
        for (int r = 0; r < 8; r++) begin
            wr_en(1'b0, ROWS[r].e0);
            wr_en(1'b1, ROWS[r].e1);
            trig_n[ROWS[r].pin] = 1'b0;
            tick(SHORT + 6);
            expect_vec("R2/R4 fall", ROWS[r].vf);
            if (vec_valid) ack();
            trig_n[ROWS[r].pin] = 1'b1;
            tick(SHORT + 6);
            expect_vec("R2/R4 rise", ROWS[r].vr);
            if (vec_valid) ack();
            expect_vec("R7 ack retires", NONE);
        end

        // R3 glitch shorter than the count is dropped
        wr_en(1'b0, 8'h33); wr_en(1'b1, 8'h33);
        trig_n[1] = 1'b0; tick(SHORT - 2); trig_n[1] = 1'b1;
        tick(SHORT + 8);
        expect_vec("R3 glitch ignored", NONE);

        // R3 long debounce
        deb_long = 1'b1;
        trig_n[2] = 1'b0;
        tick(8);
        expect_vec("R3 long not yet", NONE);
        tick(10);
        expect_vec("R3 long done", 8'd8);
        ack();
        trig_n[2] = 1'b1; tick(LONG + 6); ack();
        deb_long = 1'b0;

        // R5 simultaneous falls on pin6 and pin1, then jump (R9)
        wr_en(1'b0, 8'h03); wr_en(1'b1, 8'h03);
        trig_n[3] = 1'b0; trig_n[0] = 1'b0;
        tick(SHORT + 6);
        jump_vec = 8'd77; jump_req = 1'b1; tick(1); jump_req = 1'b0; jump_vec = 8'd0;
        expect_vec("R5 pin1 first", 8'd0);
        ack();
        expect_vec("R5 pin6 second", 8'd9);
        ack();
        expect_vec("R9 jump last", 8'd77);
        ack();
        expect_vec("R9 jump retired", NONE);
        trig_n[3] = 1'b1; trig_n[0] = 1'b1;
        tick(SHORT + 6);

        // R8 disabling a presented edge drops it
        trig_n[2] = 1'b0;
        tick(SHORT + 6);
        expect_vec("R8 pending before", 8'd8);
        wr_en(1'b1, 8'h00);
        expect_vec("R8 dropped on disable", NONE);
        trig_n[2] = 1'b1; tick(SHORT + 6);

        // R10 don't-care bits enable nothing
        wr_en(1'b0, 8'hCC);
        trig_n[0] = 1'b0; tick(SHORT + 6);
        expect_vec("R10 fall ignored bits", NONE);
        trig_n[0] = 1'b1; tick(SHORT + 6);
        expect_vec("R10 rise ignored bits", NONE);

        // R1 enables return to all-set after reset
        rst_n = 1'b0; tick(2); rst_n = 1'b1;
        tick(POR + 2); ack();
        trig_n[3] = 1'b0; tick(SHORT + 6);
        expect_vec("R1 enables set after reset", 8'd9);
        ack();
        trig_n[3] = 1'b1; tick(SHORT + 6);
        expect_vec("R1 rise enabled after reset", 8'd13);
        ack();

        finish_run();
    end
endmodule